// File: doc/BRIEF.md
# RS-485 Transceiver Direction Control

This block drives the driver-enable and receiver-enable pins of an RS-485 transceiver placed next to a UART. Software chooses one of two ways to steer the line direction by writing two mode bits in a small control register.

In handshake mode the enables simply follow the UART's RTS output. Holding RTS true keeps the driver on permanently, which is how a full-duplex link is run. In automatic mode the block watches the UART transmit line itself. A start bit switches the driver on. A programmed clocks-per-bit value and a frame length in bits then time the character. The driver is switched off one bit time after the last stop bit, unless another start bit arrives first. Software therefore never has to poll the UART's holding and shift registers before turning the transmitter off.

A read of the control register also reports that the transceiver option is fitted.

Top module: `rs485_txen`

## Requirements
- R1: After reset all registers are zero. Address 0 is the control register: bit 7 selects automatic mode and bit 6 selects handshake mode. Reading address 0 returns the two mode bits in those positions, bit 1 always set to 1, and every other bit 0, so the value after reset is 0x0002.
- R2: With neither mode bit set, the driver enable is 0 and the receiver enable is 1.
- R3: In handshake mode (bit 6 only), the driver enable equals `uart_rts_i` in the same cycle and the receiver enable is its inverse.
- R4: The driver enable and the receiver enable are never 1 in the same cycle.
- R5: When both mode bits are set, automatic mode decides the enables and `uart_rts_i` has no effect.
- R6: In automatic mode with a valid configuration, a high-to-low transition on `uart_tx_i` while no frame is being tracked sets the driver enable from the next clock cycle.
- R7: Let C be the clocks per bit and F the frame length in bits, with the start edge seen at clock edge E0. The driver stays enabled through every stop bit. When the next start edge arrives exactly F*C cycles after the previous one, the driver stays on without a gap.
- R8: When no new start edge follows, the driver enable drops at clock edge E0+F*C+C-1. That is one bit time after the end of the final stop bit.
- R9: High-to-low transitions on `uart_tx_i` inside a frame (data or parity bits) neither restart nor extend the frame timing.
- R10: When the clocks-per-bit register or the frame-length register is zero, automatic mode never enables the driver.
- R11: Clearing the automatic mode bit in the middle of a frame releases the driver from the cycle after the write. The frame being tracked is abandoned and does not resume when the bit is set again.
- R12: Address 1 holds the clocks per bit and address 2 holds the frame length in bits. Both read back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address (0 control, 1 clocks per bit, 2 frame length) |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Register read data for `cfg_addr_i`, combinational |
| uart_tx_i | input | 1 | UART serial transmit line, idle high |
| uart_rts_i | input | 1 | UART RTS output, active high |
| drv_en_o | output | 1 | Transceiver driver enable, active high |
| rcv_en_o | output | 1 | Transceiver receiver enable, active high |

## Verification
Two functions can land on the same clock edge. The guard bit that releases the driver runs out, and the start bit of the next character arrives. The bench provokes this by sending characters back to back, so each new start edge falls exactly in the first cycle after the previous stop bit. It judges the result by sampling the driver enable in the last cycle of every stop bit and at the exact release cycle after the final character. A second collision comes from a mode write landing in the middle of a frame. For that case the bench checks that the driver drops at once and stays off after automatic mode is enabled again.

// File: rtl/rs485_txen_pkg.sv
package rs485_txen_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CPB  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLEN = 2'd2;
  localparam int CTRL_AUTO_BIT = 7;
  localparam int CTRL_RTS_BIT  = 6;
  localparam int CTRL_PRES_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GUARD = 2'd2
  } trk_st_e;
endpackage

// File: rtl/rs485_txen_regs.sv
module rs485_txen_regs
  import rs485_txen_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CPB_W  = 16,
  parameter int FB_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              auto_o,
  output logic              rts_mode_o,
  output logic [CPB_W-1:0]  cpb_o,
  output logic [FB_W-1:0]   flen_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_o     <= 1'b0;
      rts_mode_o <= 1'b0;
      cpb_o      <= '0;
      flen_o     <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_CTRL: begin
          auto_o     <= wdata_i[CTRL_AUTO_BIT];
          rts_mode_o <= wdata_i[CTRL_RTS_BIT];
        end
        ADDR_CPB:  cpb_o  <= wdata_i[CPB_W-1:0];
        ADDR_FLEN: flen_o <= wdata_i[FB_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_AUTO_BIT] = auto_o;
        rdata_o[CTRL_RTS_BIT]  = rts_mode_o;
        rdata_o[CTRL_PRES_BIT] = 1'b1;
      end
      ADDR_CPB:  rdata_o = DATA_W'(cpb_o);
      ADDR_FLEN: rdata_o = DATA_W'(flen_o);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rs485_txen_trk.sv
module rs485_txen_trk
  import rs485_txen_pkg::*;
#(
  parameter int CPB_W = 16,
  parameter int FB_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tx_i,
  input  logic [CPB_W-1:0] cpb_i,
  input  logic [FB_W-1:0]  flen_i,
  output logic             busy_o
);
  trk_st_e          st_q, st_d;
  logic [CPB_W-1:0] cyc_q, cyc_d, cyc_base, cyc_last;
  logic [FB_W-1:0]  bit_q, bit_d, bit_base, bit_last;
  logic             tx_q, fall, start;

  always_comb begin
    fall     = tx_q & ~tx_i;
    // start edges are honoured only outside a frame
    start    = fall && (st_q != ST_FRAME);
    cyc_last = cpb_i - CPB_W'(1);
    bit_last = flen_i - FB_W'(1);
    cyc_base = start ? '0 : cyc_q;
    bit_base = start ? '0 : bit_q;
    st_d  = st_q;
    cyc_d = cyc_q;
    bit_d = bit_q;
    if (!en_i) begin
      st_d  = ST_IDLE;
      cyc_d = '0;
      bit_d = '0;
    end else if (start || st_q == ST_FRAME) begin
      if (cyc_base == cyc_last) begin
        cyc_d = '0;
        if (bit_base == bit_last) begin
          st_d  = ST_GUARD;
          bit_d = '0;
        end else begin
          st_d  = ST_FRAME;
          bit_d = bit_base + FB_W'(1);
        end
      end else begin
        st_d  = ST_FRAME;
        cyc_d = cyc_base + CPB_W'(1);
        bit_d = bit_base;
      end
    end else if (st_q == ST_GUARD) begin
      if (cyc_q == cyc_last) begin
        st_d  = ST_IDLE;
        cyc_d = '0;
      end else begin
        cyc_d = cyc_q + CPB_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cyc_q <= '0;
      bit_q <= '0;
      tx_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      cyc_q <= cyc_d;
      bit_q <= bit_d;
      tx_q  <= tx_i;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/rs485_txen_sel.sv
module rs485_txen_sel (
  input  logic auto_i,
  input  logic rts_mode_i,
  input  logic rts_i,
  input  logic busy_i,
  output logic drv_o,
  output logic rcv_o
);
  always_comb begin
    if (auto_i)          drv_o = busy_i;
    else if (rts_mode_i) drv_o = rts_i;
    else                 drv_o = 1'b0;
    rcv_o = ~drv_o;
  end
endmodule

// File: rtl/rs485_txen.sv
module rs485_txen
  import rs485_txen_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CPB_W  = 16,
  parameter int FB_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              uart_tx_i,
  input  logic              uart_rts_i,
  output logic              drv_en_o,
  output logic              rcv_en_o
);
  logic             mode_auto, mode_rts, trk_en, busy;
  logic [CPB_W-1:0] cpb;
  logic [FB_W-1:0]  flen;

  rs485_txen_regs #(.DATA_W(DATA_W), .CPB_W(CPB_W), .FB_W(FB_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .auto_o     (mode_auto),
    .rts_mode_o (mode_rts),
    .cpb_o      (cpb),
    .flen_o     (flen)
  );

  assign trk_en = mode_auto && (cpb != '0) && (flen != '0);

  rs485_txen_trk #(.CPB_W(CPB_W), .FB_W(FB_W)) u_trk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (trk_en),
    .tx_i   (uart_tx_i),
    .cpb_i  (cpb),
    .flen_i (flen),
    .busy_o (busy)
  );

  rs485_txen_sel u_sel (
    .auto_i     (mode_auto),
    .rts_mode_i (mode_rts),
    .rts_i      (uart_rts_i),
    .busy_i     (busy),
    .drv_o      (drv_en_o),
    .rcv_o      (rcv_en_o)
  );
endmodule

// File: rtl/rs485_txen_chk.sv
module rs485_txen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_auto,
  input logic mode_rts,
  input logic trk_en,
  input logic busy,
  input logic uart_tx_i,
  input logic uart_rts_i,
  input logic drv_en_o,
  input logic rcv_en_o
);
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_en_o && rcv_en_o)); // R4

  AST_OFF_WHEN_UNSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_auto && !mode_rts) |-> (!drv_en_o && rcv_en_o)); // R2

  AST_RTS_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_auto && mode_rts) |-> (drv_en_o == uart_rts_i)); // R3

  AST_AUTO_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_auto |-> (drv_en_o == busy)); // R5

  AST_START_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trk_en && !busy && $fell(uart_tx_i)) |=> busy); // R6

  AST_UNARMED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trk_en && !$past(trk_en)) |-> !busy); // R10
endmodule

bind rs485_txen rs485_txen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_auto  (mode_auto),
  .mode_rts   (mode_rts),
  .trk_en     (trk_en),
  .busy       (busy),
  .uart_tx_i  (uart_tx_i),
  .uart_rts_i (uart_rts_i),
  .drv_en_o   (drv_en_o),
  .rcv_en_o   (rcv_en_o)
);

// File: tb/rs485_txen_test.sv
`timescale 1ns/1ps
module rs485_txen_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        tx = 1'b1;
  logic        rts = 1'b0;
  logic        drv, rcv;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    int    fld;   // 0 drv, 1 rcv, 2 rdata
    int    val;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  rs485_txen uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we),
    .cfg_addr_i  (cfg_addr),
    .cfg_wdata_i (cfg_wdata),
    .cfg_rdata_o (cfg_rdata),
    .uart_tx_i   (tx),
    .uart_rts_i  (rts),
    .drv_en_o    (drv),
    .rcv_en_o    (rcv)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop expectations due this cycle and compare
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      int act;
      e = q.pop_front();
      total++;
      act = (e.fld == 0) ? int'(drv) : (e.fld == 1) ? int'(rcv) : int'(cfg_rdata);
      if (e.at < cyc) begin
        bad++;
        $display("FAIL %s missed slot cyc=%0d actual=%0h expected=%0h", e.tag, e.at, act, e.val);
      end else if (act != e.val) begin
        bad++;
        $display("FAIL %s cyc=%0d field=%0d actual=%0h expected=%0h", e.tag, cyc, e.fld, act, e.val);
      end
    end
  end

  task automatic expect_at(input int at, input int fld, input int val, input string tag);
    exp_t e;
    e.at = at; e.fld = fld; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] mk_frame(input logic [7:0] d, input bit par);
    logic [31:0] b;
    b = '1;
    b[0] = 1'b0;
    b[8:1] = d;
    if (par) b[9] = ^d;
    return b;
  endfunction

  // drive one character; pushes expectations derived from R6..R9
  task automatic send(input logic [31:0] bits, input int nb, input int c,
                      input bit last, input int gap_bits);
    int s;
    s = cyc;
    expect_at(s + 1, 0, 1, "R6");
    expect_at(s + (nb / 2) * c, 0, 1, "R9");
    expect_at(s + nb * c - 1, 0, 1, "R7");
    if (last) begin
      expect_at(s + nb * c + c - 1, 0, 1, "R8");
      expect_at(s + nb * c + c, 0, 0, "R8");
      expect_at(s + nb * c + c, 1, 1, "R4");
    end
    for (int i = 0; i < nb; i++) begin
      tx = bits[i];
      tick(c);
    end
    tx = 1'b1;
    tick(gap_bits * c);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired at cyc=%0d actual=hung expected=finished", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k;
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // reset state
    cfg_addr = 2'd0;
    expect_at(cyc, 2, 'h0002, "R1");
    expect_at(cyc, 0, 0, "R2");
    expect_at(cyc, 1, 1, "R2");
    tick(1);
    cfg_addr = 2'd1; expect_at(cyc, 2, 0, "R1"); tick(1);
    cfg_addr = 2'd2; expect_at(cyc, 2, 0, "R1"); tick(1);

    // automatic mode with zero timing registers
    wr(2'd0, 16'h0080);
    tx = 1'b0;
    expect_at(cyc + 2, 0, 0, "R10");
    expect_at(cyc + 5, 0, 0, "R10");
    tick(6); tx = 1'b1; tick(2);
    wr(2'd2, 16'd10);
    tx = 1'b0;
    expect_at(cyc + 3, 0, 0, "R10");
    tick(5); tx = 1'b1; tick(2);

    // handshake mode, including full duplex hold
    wr(2'd0, 16'h0040);
    rts = 1'b1;
    expect_at(cyc, 0, 1, "R3");
    expect_at(cyc, 1, 0, "R4");
    expect_at(cyc + 20, 0, 1, "R3");
    tick(21);
    rts = 1'b0;
    expect_at(cyc, 0, 0, "R3");
    expect_at(cyc, 1, 1, "R3");
    cfg_addr = 2'd0;
    expect_at(cyc, 2, 'h0042, "R1");
    tick(1);

    // timing registers
    wr(2'd1, 16'd4);
    wr(2'd2, 16'd10);
    cfg_addr = 2'd1; expect_at(cyc, 2, 4, "R12"); tick(1);
    cfg_addr = 2'd2; expect_at(cyc, 2, 10, "R12"); tick(1);

    // both modes set: automatic wins over RTS
    rts = 1'b1;
    wr(2'd0, 16'h00C0);
    cfg_addr = 2'd0;
    expect_at(cyc, 0, 0, "R5");
    expect_at(cyc, 2, 'h00C2, "R1");
    tick(2);

    // back-to-back characters, C=4 F=10
    send(mk_frame(8'h55, 1'b0), 10, 4, 1'b0, 0);
    send(mk_frame(8'hA3, 1'b0), 10, 4, 1'b0, 0);
    send(mk_frame(8'h0F, 1'b0), 10, 4, 1'b1, 3);
    tick(2);

    // mode cleared mid-frame
    tx = 1'b0;
    tick(4);
    expect_at(cyc, 0, 1, "R6");
    wr(2'd0, 16'h0000);
    expect_at(cyc, 0, 0, "R11");
    expect_at(cyc, 1, 1, "R11");
    tick(2); tx = 1'b1; tick(4);
    wr(2'd0, 16'h0080);
    expect_at(cyc, 0, 0, "R11");
    expect_at(cyc + 3, 0, 0, "R11");
    tick(5);

    // gapped characters with parity, C=3 F=11
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd11);
    tick(1);
    send(mk_frame(8'h81, 1'b1), 11, 3, 1'b1, 3);
    send(mk_frame(8'h7E, 1'b1), 11, 3, 1'b1, 3);

    k = 0;
    while (q.size() > 0 && k < 100) begin
      tick(1);
      k++;
    end
    tick(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule